// File: doc/BRIEF.md
# Region-Policy Write Buffer Controller

This block sits between a processor's store port and an external system bus. For every store it picks one of three outcomes from two global enables (cache on, write buffer on) and the target region's two attributes (cacheable, bufferable). The store can be absorbed by the cache. It can be queued in a small write FIFO while the processor moves on. Or it can be performed directly on the bus while the processor is stalled until the bus acknowledges. The four region types are noncacheable-nonbuffered, noncacheable-buffered, write-through and copy-back.

A second input takes dirty-line eviction words from a copy-back cache. These always go through the FIFO, even when the buffer enable is off. In copy-back mode with the buffer disabled, store misses are therefore the only accesses that stall on the bus. The FIFO drains oldest first, one transfer at a time. A direct write waits until the FIFO is empty, so the bus sees stores in program order.

Top module: `wbuf_policy_ctrl`

## Requirements
- R1: A store whose effective region is noncacheable-nonbuffered (bufferable=0 with cacheable=0, or with the cache disabled) is driven directly on the bus. The processor stall stays high until the cycle in which the bus acknowledges that store.
- R2: With the buffer enabled, a store to a noncacheable-bufferable region (cacheable=0, bufferable=1) is queued without a stall when the FIFO has room and no eviction is offered in the same cycle.
- R3: With the cache enabled, a store to a write-through region (cacheable=1, bufferable=0) is queued when the buffer is enabled, and performed directly with a stall when it is disabled.
- R4: With the cache enabled, a store to a copy-back region (cacheable=1, bufferable=1) that hits is absorbed with no stall and no bus traffic. A miss is queued when the buffer is enabled, and performed directly with a stall when it is disabled.
- R5: With the cache disabled, the cacheable attribute has no effect, and a store is handled by its bufferable attribute alone.
- R6: Eviction words are queued whatever the buffer enable says. The eviction ready output is high exactly when the FIFO holds fewer than its depth of entries.
- R7: The FIFO holds DEPTH entries (default 8). A buffered store that meets a full FIFO is stalled.
- R8: A direct store is not driven on the bus until every earlier queued entry has been acknowledged. It is the next transfer after the last one of them.
- R9: Queued entries leave in arrival order, one at a time. Address, data and byte enables stay stable while the request is high, and each entry is retired on the acknowledge.
- R10: When an eviction and a buffered store are offered in the same cycle, the eviction is queued first and the store is stalled for that cycle.
- R11: After reset the FIFO is empty, no bus request is raised, the stall is low while no store is offered, and eviction ready is high.
- R12: With the buffer disabled, a store to a noncacheable-bufferable region is performed directly with a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Global cache enable |
| wbuf_en | input | 1 | Global write buffer enable |
| cpu_wr_valid | input | 1 | Store offered; held with its fields until accepted |
| cpu_wr_addr | input | ADDR_W | Store address |
| cpu_wr_data | input | DATA_W | Store data |
| cpu_wr_be | input | DATA_W/8 | Store byte enables |
| cpu_rgn_cacheable | input | 1 | Region cacheable attribute |
| cpu_rgn_bufferable | input | 1 | Region bufferable attribute |
| cpu_wr_hit | input | 1 | Store hits the cache (used in copy-back regions) |
| cpu_stall | output | 1 | Store not accepted this cycle |
| evict_valid | input | 1 | Dirty-line eviction word offered |
| evict_addr | input | ADDR_W | Eviction word address |
| evict_data | input | DATA_W | Eviction word data |
| evict_ready | output | 1 | Eviction word accepted this cycle |
| ext_req | output | 1 | External write request |
| ext_addr | output | ADDR_W | External write address |
| ext_data | output | DATA_W | External write data |
| ext_be | output | DATA_W/8 | External write byte enables (all ones for evictions) |
| ext_ack | input | 1 | External write completes this cycle |

## Verification
The bench sweeps all 32 combinations of the two enables, the two region attributes and the hit flag, and checks the stall and bus outcome of each against a policy computed in the bench. A wrong decode would stall where it should queue, or would put an absorbed copy-back hit on the bus. It fills the FIFO to its depth and then offers a ninth store and a direct store: a design with no full check would overwrite the oldest entry, and a direct store that did not wait for the drain would appear on the bus ahead of queued data. Collisions between an eviction and a buffered store are checked for ordering, which catches a design that drops or reverses one of them. Evictions are checked with the buffer disabled, to catch a design that lets the enable bit send evictions down the direct path.

// File: rtl/wbuf_pkg.sv
// Shared types for the region-policy write buffer controller.
package wbuf_pkg;
    // Outcome chosen for one processor store.
    typedef enum logic [1:0] {
        ACT_ABSORB = 2'd0,  // cache takes it, nothing external
        ACT_BUFFER = 2'd1,  // queued in the write FIFO
        ACT_DIRECT = 2'd2   // performed on the bus, processor stalls
    } wr_action_e;
endpackage

// File: rtl/wbuf_policy_decode.sv
// Policy decoder: maps global enables, region attributes and the hit flag
// to a store outcome. Purely combinational.
// Assumes the hit flag is meaningful only for copy-back regions.
module wbuf_policy_decode
    import wbuf_pkg::*;
(
    input  logic       cache_en,
    input  logic       wbuf_en,
    input  logic       rgn_cacheable,
    input  logic       rgn_bufferable,
    input  logic       wr_hit,
    output wr_action_e action
);
    logic cacheable_eff;

    // A region counts as cacheable only while the cache is on.
    assign cacheable_eff = cache_en & rgn_cacheable;

    // Pick the outcome for the current store.
    always_comb begin
        if (!cacheable_eff) begin
            action = (rgn_bufferable && wbuf_en) ? ACT_BUFFER : ACT_DIRECT;
        end else if (!rgn_bufferable) begin
            action = wbuf_en ? ACT_BUFFER : ACT_DIRECT;
        end else if (wr_hit) begin
            action = ACT_ABSORB;
        end else begin
            action = wbuf_en ? ACT_BUFFER : ACT_DIRECT;
        end
    end
endmodule

// File: rtl/wbuf_fifo.sv
// Synchronous FIFO for queued bus writes. One push and one pop per cycle.
// Assumes the caller never pushes when full and never pops when empty.
module wbuf_fifo #(
    parameter int WIDTH = 68,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed entry.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Track pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/wbuf_policy_ctrl.sv
// Region-policy write buffer controller (top).
// Decodes a per-store policy, queues buffered stores and cache evictions in
// a FIFO, and performs unbuffered stores directly once the FIFO has drained.
// Assumes: stores and the external request hold their fields until accepted;
// the bus completes a transfer in any cycle where ext_req and ext_ack are high.
module wbuf_policy_ctrl
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int BE_W  = DATA_W / 8,
    localparam int ENT_W = ADDR_W + DATA_W + BE_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              wbuf_en,
    input  logic              cpu_wr_valid,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic [BE_W-1:0]   cpu_wr_be,
    input  logic              cpu_rgn_cacheable,
    input  logic              cpu_rgn_bufferable,
    input  logic              cpu_wr_hit,
    output logic              cpu_stall,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [DATA_W-1:0] evict_data,
    output logic              evict_ready,
    output logic              ext_req,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_data,
    output logic [BE_W-1:0]   ext_be,
    input  logic              ext_ack
);
    wr_action_e       action;
    logic             cpu_wants_buf;
    logic             cpu_wants_dir;
    logic             evict_push;
    logic             cpu_push;
    logic             fifo_push;
    logic             fifo_pop;
    logic [ENT_W-1:0] fifo_din;
    logic [ENT_W-1:0] fifo_dout;
    logic             fifo_empty;
    logic             fifo_full;
    logic [CNT_W-1:0] fifo_cnt;
    logic             direct_busy;
    logic             sel_direct;

    wbuf_policy_decode u_decode (
        .cache_en       (cache_en),
        .wbuf_en        (wbuf_en),
        .rgn_cacheable  (cpu_rgn_cacheable),
        .rgn_bufferable (cpu_rgn_bufferable),
        .wr_hit         (cpu_wr_hit),
        .action         (action)
    );

    // Classify the offered store.
    assign cpu_wants_buf = cpu_wr_valid && (action == ACT_BUFFER);
    assign cpu_wants_dir = cpu_wr_valid && (action == ACT_DIRECT);

    // Evictions take the single push slot first; stores use it otherwise.
    assign evict_ready = !fifo_full;
    assign evict_push  = evict_valid && !fifo_full;
    assign cpu_push    = cpu_wants_buf && !fifo_full && !evict_valid;
    assign fifo_push   = evict_push || cpu_push;
    assign fifo_din    = evict_push ? {evict_addr, evict_data, {BE_W{1'b1}}}
                                    : {cpu_wr_addr, cpu_wr_data, cpu_wr_be};

    wbuf_fifo #(
        .WIDTH (ENT_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    // Bus owner: a started direct store keeps the bus; a new one needs an empty FIFO.
    assign sel_direct = direct_busy || (fifo_empty && cpu_wants_dir);

    // Remember a direct store that is on the bus but not yet acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            direct_busy <= 1'b0;
        end else begin
            direct_busy <= sel_direct && !ext_ack;
        end
    end

    // Drive the external write from the FIFO head or the direct store.
    always_comb begin
        ext_req = sel_direct || !fifo_empty;
        if (sel_direct) begin
            ext_addr = cpu_wr_addr;
            ext_data = cpu_wr_data;
            ext_be   = cpu_wr_be;
        end else begin
            {ext_addr, ext_data, ext_be} = fifo_dout;
        end
    end

    assign fifo_pop = !sel_direct && !fifo_empty && ext_ack;

    // Hold the processor until its store is queued, absorbed or acknowledged.
    always_comb begin
        cpu_stall = 1'b0;
        if (cpu_wr_valid) begin
            unique case (action)
                ACT_BUFFER: cpu_stall = !cpu_push;
                ACT_DIRECT: cpu_stall = !(sel_direct && ext_ack);
                default:    cpu_stall = 1'b0;
            endcase
        end
    end
endmodule

// Property checker for the write buffer controller, attached by bind.
// Assumes the bench keeps store fields stable while cpu_stall is high.
module wbuf_policy_ctrl_chk
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int BE_W  = DATA_W / 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr_valid,
    input logic              cpu_stall,
    input wr_action_e        action,
    input logic              evict_valid,
    input logic              evict_ready,
    input logic              ext_req,
    input logic              ext_ack,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [DATA_W-1:0] ext_data,
    input logic [BE_W-1:0]   ext_be,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              direct_busy
);
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_ack |=> ext_req && $stable(ext_addr)
                                && $stable(ext_data) && $stable(ext_be));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    a_r7_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_valid && action == ACT_BUFFER && fifo_full |-> cpu_stall);

    a_r1_direct_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_valid && action == ACT_DIRECT && !cpu_stall |-> ext_req && ext_ack);

    a_r8_direct_waits_drain: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_valid && action == ACT_DIRECT && !direct_busy && !fifo_empty
        |-> cpu_stall);

    a_r4_absorb_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_valid && action == ACT_ABSORB |-> !cpu_stall);

    a_r6_evict_queued: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid && evict_ready |=> !fifo_empty);

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> fifo_empty && !direct_busy);
endmodule

bind wbuf_policy_ctrl wbuf_policy_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_valid (cpu_wr_valid),
    .cpu_stall    (cpu_stall),
    .action       (action),
    .evict_valid  (evict_valid),
    .evict_ready  (evict_ready),
    .ext_req      (ext_req),
    .ext_ack      (ext_ack),
    .ext_addr     (ext_addr),
    .ext_data     (ext_data),
    .ext_be       (ext_be),
    .fifo_empty   (fifo_empty),
    .fifo_full    (fifo_full),
    .fifo_cnt     (fifo_cnt),
    .direct_busy  (direct_busy)
);

// File: tb/wbuf_policy_ctrl_bench.sv
// Self-checking bench: policy sweep, FIFO fill and drain ordering, collisions.
module wbuf_policy_ctrl_bench;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;
    localparam int BE_W   = DATA_W / 8;
    localparam int A_ABS = 0, A_BUF = 1, A_DIR = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              cache_en = 1'b0, wbuf_en = 1'b0;
    logic              cpu_wr_valid = 1'b0;
    logic [ADDR_W-1:0] cpu_wr_addr = '0;
    logic [DATA_W-1:0] cpu_wr_data = '0;
    logic [BE_W-1:0]   cpu_wr_be = '0;
    logic              rgn_c = 1'b0, rgn_b = 1'b0, hit = 1'b0;
    logic              cpu_stall;
    logic              evict_valid = 1'b0;
    logic [ADDR_W-1:0] evict_addr = '0;
    logic [DATA_W-1:0] evict_data = '0;
    logic              evict_ready;
    logic              ext_req;
    logic [ADDR_W-1:0] ext_addr;
    logic [DATA_W-1:0] ext_data;
    logic [BE_W-1:0]   ext_be;
    logic              ext_ack = 1'b0;

    wbuf_policy_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_wbuf_policy_ctrl (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .wbuf_en(wbuf_en),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr),
        .cpu_wr_data(cpu_wr_data), .cpu_wr_be(cpu_wr_be),
        .cpu_rgn_cacheable(rgn_c), .cpu_rgn_bufferable(rgn_b), .cpu_wr_hit(hit),
        .cpu_stall(cpu_stall), .evict_valid(evict_valid), .evict_addr(evict_addr),
        .evict_data(evict_data), .evict_ready(evict_ready), .ext_req(ext_req),
        .ext_addr(ext_addr), .ext_data(ext_data), .ext_be(ext_be), .ext_ack(ext_ack)
    );

    int checks = 0;
    int fails  = 0;

    // Completed bus transfers, in order.
    logic [ADDR_W-1:0] log_addr [64];
    int log_n = 0;
    always @(posedge clk) begin
        if (rst_n && ext_req && ext_ack && log_n < 64) begin
            log_addr[log_n] <= ext_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected outcome from the requirements.
    function automatic int exp_action(bit ce, bit we, bit c, bit b, bit h);
        if (!(ce && c)) return (b && we) ? A_BUF : A_DIR;
        if (!b)         return we ? A_BUF : A_DIR;
        if (h)          return A_ABS;
        return we ? A_BUF : A_DIR;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        #1;
        chk(ext_req == 1'b0, "R11 req", ext_req, 0);
        chk(cpu_stall == 1'b0, "R11 stall", cpu_stall, 0);
        chk(evict_ready == 1'b1, "R11 ready", evict_ready, 1);
        @(negedge clk) rst_n = 1'b1;

        // Policy sweep over enables, attributes and hit.
        for (int idx = 0; idx < 32; idx++) begin
            int    ea;
            string tag;
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            logic [BE_W-1:0]   be;
            bit ce, we, c, b, h;
            {ce, we, c, b, h} = 5'(idx);
            ea = exp_action(ce, we, c, b, h);
            if (!ce && c)     tag = "R5";
            else if (ce && c) tag = b ? "R4" : "R3";
            else              tag = b ? (we ? "R2" : "R12") : "R1";
            a  = 32'h100 + 32'(idx) * 4;
            d  = 32'hD000_0000 | 32'(idx);
            be = 4'(idx) ^ 4'hA;
            @(negedge clk);
            cache_en = ce; wbuf_en = we; rgn_c = c; rgn_b = b; hit = h;
            cpu_wr_valid = 1'b1; cpu_wr_addr = a; cpu_wr_data = d; cpu_wr_be = be;
            #1;
            chk(cpu_stall == (ea == A_DIR), tag, cpu_stall, ea == A_DIR);
            chk(ext_req == (ea == A_DIR), tag, ext_req, ea == A_DIR);
            if (ea == A_DIR) begin
                chk(ext_addr == a && ext_data == d && ext_be == be, tag, ext_data, d);
                @(negedge clk); #1;
                chk(cpu_stall == 1'b1, tag, cpu_stall, 1);
                ext_ack = 1'b1; #1;
                chk(cpu_stall == 1'b0, tag, cpu_stall, 0);
                @(negedge clk);
                cpu_wr_valid = 1'b0; ext_ack = 1'b0; #1;
                chk(ext_req == 1'b0, tag, ext_req, 0);
            end else begin
                @(negedge clk);
                cpu_wr_valid = 1'b0; #1;
                chk(ext_req == (ea == A_BUF), tag, ext_req, ea == A_BUF);
                if (ea == A_BUF) begin
                    chk(ext_addr == a && ext_data == d && ext_be == be, tag, ext_addr, a);
                    ext_ack = 1'b1;
                    @(negedge clk);
                    ext_ack = 1'b0; #1;
                    chk(ext_req == 1'b0, "R9 retire", ext_req, 0);
                end
            end
        end

        // Fill the FIFO, then a ninth store and a direct store.
        cache_en = 1'b0; wbuf_en = 1'b1; rgn_c = 1'b0; rgn_b = 1'b1; hit = 1'b0;
        cpu_wr_be = 4'hF;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            cpu_wr_valid = 1'b1; cpu_wr_addr = 32'h200 + 32'(i) * 4; #1;
            chk(cpu_stall == 1'b0, "R2 fill", cpu_stall, 0);
        end
        @(negedge clk);
        cpu_wr_addr = 32'h220; #1;
        chk(cpu_stall == 1'b1, "R7 full", cpu_stall, 1);
        chk(evict_ready == 1'b0, "R6 full", evict_ready, 0);
        @(negedge clk);
        rgn_b = 1'b0; cpu_wr_addr = 32'h300; #1;
        chk(cpu_stall == 1'b1, "R8 wait", cpu_stall, 1);
        chk(ext_addr == 32'h200, "R8 head", ext_addr, 32'h200);
        base = log_n;
        ext_ack = 1'b1;
        repeat (DEPTH) @(negedge clk);
        #1;
        chk(cpu_stall == 1'b0, "R8 done", cpu_stall, 0);
        chk(ext_addr == 32'h300, "R8 addr", ext_addr, 32'h300);
        @(negedge clk);
        cpu_wr_valid = 1'b0; ext_ack = 1'b0; #1;
        chk(log_n - base == DEPTH + 1, "R9 count", log_n - base, DEPTH + 1);
        for (int k = 0; k < DEPTH; k++)
            chk(log_addr[base+k] == 32'h200 + 32'(k) * 4, "R9 order",
                log_addr[base+k], 32'h200 + 32'(k) * 4);
        chk(log_addr[base+DEPTH] == 32'h300, "R8 after", log_addr[base+DEPTH], 32'h300);

        // Eviction and buffered store in the same cycle.
        @(negedge clk);
        rgn_b = 1'b1; cpu_wr_valid = 1'b1; cpu_wr_addr = 32'h500;
        evict_valid = 1'b1; evict_addr = 32'h400; evict_data = 32'hE0; #1;
        chk(cpu_stall == 1'b1, "R10 stall", cpu_stall, 1);
        chk(evict_ready == 1'b1, "R10 ready", evict_ready, 1);
        @(negedge clk);
        evict_valid = 1'b0; #1;
        chk(cpu_stall == 1'b0, "R10 next", cpu_stall, 0);
        @(negedge clk);
        cpu_wr_valid = 1'b0; base = log_n; ext_ack = 1'b1;
        repeat (2) @(negedge clk);
        ext_ack = 1'b0; #1;
        chk(log_n - base == 2, "R10 count", log_n - base, 2);
        chk(log_addr[base] == 32'h400, "R10 first", log_addr[base], 32'h400);
        chk(log_addr[base+1] == 32'h500, "R10 second", log_addr[base+1], 32'h500);

        // Copy-back with buffer off: eviction queued, miss goes direct after it.
        @(negedge clk);
        cache_en = 1'b1; wbuf_en = 1'b0; rgn_c = 1'b1; rgn_b = 1'b1; hit = 1'b0;
        evict_valid = 1'b1; evict_addr = 32'h600; evict_data = 32'hE1;
        @(negedge clk);
        evict_valid = 1'b0; #1;
        chk(ext_req == 1'b1 && ext_addr == 32'h600, "R6 queued", ext_addr, 32'h600);
        chk(ext_be == 4'hF, "R6 be", ext_be, 4'hF);
        @(negedge clk);
        cpu_wr_valid = 1'b1; cpu_wr_addr = 32'h700; #1;
        chk(cpu_stall == 1'b1, "R4 miss", cpu_stall, 1);
        chk(ext_addr == 32'h600, "R8 evict first", ext_addr, 32'h600);
        ext_ack = 1'b1;
        @(negedge clk); #1;
        chk(cpu_stall == 1'b0 && ext_addr == 32'h700, "R4 direct", ext_addr, 32'h700);
        @(negedge clk);
        cpu_wr_valid = 1'b0; ext_ack = 1'b0; #1;
        chk(ext_req == 1'b0, "R9 idle", ext_req, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule